// File: doc/BRIEF.md
# Pipelined Canonical Signed Digit Recoder with Segmented Scan

This block turns a signed operand of `WIDTH` bits into its canonical signed digit form, one digit per operand bit, through two register stages. The first stage captures the operand bits together with the carries of the recoding chain. The second stage turns each captured bit and carry pair into a digit coded as a sign bit and a magnitude bit. A new operand can be accepted on every clock, and its digits appear two rising edges later.

Every register of both stages also sits in a shift path, reached through a 2:1 multiplexer in front of it. When `test_en` is high the registers stop loading and shift instead. The operand is split into `NUM_PATHS` equal segments, and each segment is an independent scan path with its own serial input and output. The multiplexer that feeds the carry into the bottom of each segment doubles as the serial entry point, so the scan paths add no logic to the carry chain. The carry into the upper half-word is formed by a separate look-ahead generator instead of rippling across the halves. For this reason the two halves can never share a single path, and there are always at least two paths. A known operand can be captured in normal mode and then shifted out. The first wrong bit in the stream then gives the position of a faulty register.

Top module: `csd_scan_recoder`

## Requirements
- R1: With `test_en` low, the digits on the outputs two rising edges after an operand is applied decode to that operand read as two's complement: the sum over i of d(i)·2^i, where digit i is {`digit_sign[i]`, `digit_mag[i]`} and 2'b00 = 0, 2'b01 = +1, 2'b11 = −1.
- R2: In normal operation the code 2'b10 never appears on any digit.
- R3: In normal operation no two neighbouring digits are both nonzero.
- R4: Each digit equals x(i) + c(i) − 2·c(i+1), with c(0) = 0, c(i+1) the majority of x(i), x(i+1) and c(i), and x(WIDTH) = x(WIDTH−1). A different operand may be applied on every clock, and each result appears exactly two edges after its operand.
- R5: A synchronous active-low reset clears every register, even with `test_en` high. All digits then read 2'b00 and every `scan_out` bit reads 0.
- R6: With `test_en` high, each path moves one bit per clock. A bit placed on `scan_in[p]` appears on `scan_out[p]` 4·WIDTH/NUM_PATHS edges later, whatever the operand does.
- R7: The scan paths are independent: the stream out of one path depends only on its own serial input.
- R8: Inside path p, which covers digits p·S to p·S+S−1 with S = WIDTH/NUM_PATHS, the shift order from the input end is as follows. First come the pairs (carry, operand bit) for the digits in ascending order. Then come the pairs (magnitude, sign) in ascending order. `scan_out[p]` is the sign register of the top digit of the segment.
- R9: In normal mode the carry register of digit 0 always captures 0.
- R10: The carry register at the half-word boundary captures the look-ahead value, and that value equals the carry a full ripple through the lower half would give.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| operand | input | WIDTH | Two's complement value to recode |
| test_en | input | 1 | 1 = shift the registers, 0 = recode |
| scan_in | input | NUM_PATHS | Serial input of each scan path |
| digit_sign | output | WIDTH | Sign bit of each recoded digit |
| digit_mag | output | WIDTH | Magnitude bit of each recoded digit |
| scan_out | output | NUM_PATHS | Serial output of each scan path |

## Verification
The assertions check on every clock that the digit codes are legal and non-adjacent once two normal edges have passed. They also check that the bottom carry captures zero, that the look-ahead carry agrees with the ripple carry out of the lower half, that the top carry equals the sign bit, and that each path's first register takes the serial input while shifting. Only the bench's scenarios can show the rest. These are the arithmetic value of every 8-bit operand under streaming input in two orders, the exact digit pattern, the register order seen when a captured operand is unloaded, the delay through each path and the independence of the paths, and a reset applied while the chain is shifting.

// File: rtl/csd_recoder_pkg.sv
// Package: shared digit coding for the canonical signed digit recoder.
// Assumes a digit is carried as {sign, magnitude} on two separate vectors.
package csd_recoder_pkg;

    // Digit codes {sign, magnitude}; 2'b10 is never produced.
    localparam logic [1:0] DIGIT_ZERO = 2'b00;
    localparam logic [1:0] DIGIT_PLUS = 2'b01;
    localparam logic [1:0] DIGIT_MINUS = 2'b11;

    // Registers spent per digit: two capture registers, two digit registers.
    localparam int REGS_PER_DIGIT = 4;

endpackage

// File: rtl/csd_half_lookahead.sv
// Module: csd_half_lookahead
// Forms the recoding carry into the upper half-word straight from the
// lower operand bits. It does not wait for the ripple through the lower
// segments. In the recurrence, a pair of equal neighbouring bits fixes the
// carry to their value, and a pair of unequal bits passes the lower carry
// through. So the carry is the value of the highest equal pair, or the
// chain's base carry of 0 if there is none.
// Assumes: x_span holds operand bits 0..LOW_DIGITS; normal mode only.
module csd_half_lookahead #(
    parameter int LOW_DIGITS = 4
) (
    input  logic [LOW_DIGITS:0] x_span,
    output logic                carry_half
);

    // Pick the value of the highest bit pair that generates or kills.
    always_comb begin
        carry_half = 1'b0;
        for (int j = 0; j < LOW_DIGITS; j++) begin
            if (x_span[j] == x_span[j+1]) begin
                carry_half = x_span[j];
            end
        end
    end

endmodule

// File: rtl/csd_scan_segment.sv
// Module: csd_scan_segment
// One slice of SEG_DIGITS digits, which is also one scan path. Stage one
// captures (carry, operand bit) per digit. Stage two turns these into
// (magnitude, sign). In front of every register a 2:1 multiplexer picks
// either the captured value or its neighbour in the chain. The carry
// multiplexer at the bottom of the segment is also the serial entry.
// Assumes: carry_in is the normal-mode carry into the lowest digit. When
// IS_TOP is set, the carry above the top digit equals its own operand bit
// (sign extension), and c_above_q is then unused.
module csd_scan_segment #(
    parameter int SEG_DIGITS = 4,
    parameter bit IS_TOP     = 1'b0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  test_en,
    input  logic                  scan_in,
    input  logic [SEG_DIGITS-1:0] x_in,
    input  logic                  x_above,
    input  logic                  carry_in,
    input  logic                  c_above_q,
    output logic [SEG_DIGITS-1:0] digit_sign,
    output logic [SEG_DIGITS-1:0] digit_mag,
    output logic                  carry_out,
    output logic                  c_base_q,
    output logic                  scan_out
);
    import csd_recoder_pkg::*;

    localparam int CHAIN_LEN = REGS_PER_DIGIT * SEG_DIGITS;
    localparam int DIG_BASE  = 2 * SEG_DIGITS;

    logic [SEG_DIGITS:0]  carry;
    logic [CHAIN_LEN-1:0] chain_q;
    logic [CHAIN_LEN-1:0] capture_d;
    logic [CHAIN_LEN-1:0] chain_d;

    // Carry entry: the serial bit while shifting, the chain carry otherwise.
    assign carry[0] = test_en ? scan_in : carry_in;

    for (genvar j = 0; j < SEG_DIGITS; j++) begin : g_digit
        logic x_next;
        logic c_next_q;
        logic mag_now;

        if (j == SEG_DIGITS - 1) begin : g_edge
            assign x_next = x_above;
            if (IS_TOP) begin : g_sign_ext
                assign c_next_q = chain_q[2*j+1];
            end else begin : g_link
                assign c_next_q = c_above_q;
            end
        end else begin : g_inner
            assign x_next   = x_in[j+1];
            assign c_next_q = chain_q[2*j+2];
        end

        // Ripple carry: majority of this bit, the next bit and this carry.
        assign carry[j+1] = (x_in[j] & x_next) | (x_in[j] & carry[j])
                          | (x_next & carry[j]);

        // A digit is nonzero when exactly one of bit and carry is set.
        assign mag_now = chain_q[2*j] ^ chain_q[2*j+1];

        assign capture_d[2*j]              = carry[j];
        assign capture_d[2*j+1]            = x_in[j];
        assign capture_d[DIG_BASE+2*j]     = mag_now;
        assign capture_d[DIG_BASE+2*j+1]   = mag_now & c_next_q;

        assign digit_mag[j]  = chain_q[DIG_BASE+2*j];
        assign digit_sign[j] = chain_q[DIG_BASE+2*j+1];
    end

    // Scan multiplexer ahead of every register; position 0 is the carry entry.
    assign chain_d = test_en ? {chain_q[CHAIN_LEN-2:0], carry[0]} : capture_d;

    // Both pipeline stages and the scan path in one register vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign carry_out = carry[SEG_DIGITS];
    assign c_base_q  = chain_q[0];
    assign scan_out  = chain_q[CHAIN_LEN-1];

    // R6: while shifting, the first register takes the serial input bit.
    assert_scan_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        test_en |=> (chain_q[0] == $past(scan_in)));

endmodule

// File: rtl/csd_scan_recoder.sv
// Module: csd_scan_recoder (top)
// Recodes a WIDTH-bit two's complement operand into WIDTH signed digits over
// two register stages. NUM_PATHS segments form independent scan paths. The
// carry into the bottom segment is tied low in normal mode. The segment at
// the half-word boundary takes its carry from the look-ahead generator, and
// every other segment takes the ripple from the segment below.
// Assumes: NUM_PATHS is even and divides WIDTH, and WIDTH >= 2.
module csd_scan_recoder #(
    parameter int WIDTH     = 8,
    parameter int NUM_PATHS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [WIDTH-1:0]     operand,
    input  logic                 test_en,
    input  logic [NUM_PATHS-1:0] scan_in,
    output logic [WIDTH-1:0]     digit_sign,
    output logic [WIDTH-1:0]     digit_mag,
    output logic [NUM_PATHS-1:0] scan_out
);

    localparam int SEG       = WIDTH / NUM_PATHS;
    localparam int HALF      = WIDTH / 2;
    localparam int HALF_PATH = NUM_PATHS / 2;

    logic                 la_carry;
    logic [NUM_PATHS-1:0] carry_into;
    logic [NUM_PATHS-1:0] carry_out;
    logic [NUM_PATHS-1:0] c_base_q;
    logic [1:0]           normal_age_q;

    csd_half_lookahead #(
        .LOW_DIGITS (HALF)
    ) i_lookahead (
        .x_span     (operand[HALF:0]),
        .carry_half (la_carry)
    );

    for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
        logic x_above;
        logic c_above_q;

        if (p == 0) begin : g_base
            assign carry_into[p] = 1'b0;
        end else if (p == HALF_PATH) begin : g_half
            assign carry_into[p] = la_carry;
        end else begin : g_ripple
            assign carry_into[p] = carry_out[p-1];
        end

        if (p == NUM_PATHS - 1) begin : g_last
            assign x_above   = operand[WIDTH-1];
            assign c_above_q = 1'b0;
        end else begin : g_mid
            assign x_above   = operand[(p+1)*SEG];
            assign c_above_q = c_base_q[p+1];
        end

        csd_scan_segment #(
            .SEG_DIGITS (SEG),
            .IS_TOP     (p == NUM_PATHS - 1)
        ) i_segment (
            .clk        (clk),
            .rst_n      (rst_n),
            .test_en    (test_en),
            .scan_in    (scan_in[p]),
            .x_in       (operand[p*SEG +: SEG]),
            .x_above    (x_above),
            .carry_in   (carry_into[p]),
            .c_above_q  (c_above_q),
            .digit_sign (digit_sign[p*SEG +: SEG]),
            .digit_mag  (digit_mag[p*SEG +: SEG]),
            .carry_out  (carry_out[p]),
            .c_base_q   (c_base_q[p]),
            .scan_out   (scan_out[p])
        );
    end

    // Counts normal edges since the last shift (saturating at 2), for checks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            normal_age_q <= 2'd0;
        end else if (test_en) begin
            normal_age_q <= 2'd0;
        end else if (normal_age_q != 2'd2) begin
            normal_age_q <= normal_age_q + 2'd1;
        end
    end

    // R2: the illegal code {1,0} never reaches a digit output.
    assert_code_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (normal_age_q == 2'd2) |-> ((digit_sign & ~digit_mag) == '0));

    // R3: neighbouring digits are never both nonzero.
    assert_nonadjacent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (normal_age_q == 2'd2) |-> ((digit_mag & (digit_mag >> 1)) == '0));

    // R9: the base carry register captures zero on every normal edge.
    assert_base_carry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !test_en |=> (c_base_q[0] == 1'b0));

    // R10: look-ahead carry agrees with the ripple out of the lower half.
    assert_lookahead_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !test_en |-> (la_carry == carry_out[HALF_PATH-1]));

    // R4: the carry past the top digit equals the sign bit.
    assert_top_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !test_en |-> (carry_out[NUM_PATHS-1] == operand[WIDTH-1]));

endmodule

// File: tb/test_csd_scan_recoder.sv
`timescale 1ns/1ps
// Bench: exhaustive recoding sweeps, capture-and-unload of the chains,
// serial shifting through both paths, and reset while shifting.
module test_csd_scan_recoder;

    localparam int WIDTH     = 8;
    localparam int NUM_PATHS = 2;
    localparam int SEG       = WIDTH / NUM_PATHS;
    localparam int CHAIN     = 4 * SEG;
    localparam int NVALS     = 1 << WIDTH;

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic [WIDTH-1:0]     operand;
    logic                 test_en;
    logic [NUM_PATHS-1:0] scan_in;
    logic [WIDTH-1:0]     digit_sign;
    logic [WIDTH-1:0]     digit_mag;
    logic [NUM_PATHS-1:0] scan_out;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    csd_scan_recoder #(
        .WIDTH     (WIDTH),
        .NUM_PATHS (NUM_PATHS)
    ) i_csd_scan_recoder (
        .clk        (clk),
        .rst_n      (rst_n),
        .operand    (operand),
        .test_en    (test_en),
        .scan_in    (scan_in),
        .digit_sign (digit_sign),
        .digit_mag  (digit_mag),
        .scan_out   (scan_out)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Carries of the recurrence, c(0) = 0, sign bit extended.
    function automatic logic [WIDTH:0] ref_carry(input logic [WIDTH-1:0] x);
        logic [WIDTH:0] c;
        c[0] = 1'b0;
        for (int i = 0; i < WIDTH; i++) begin
            int nxt;
            int sum;
            nxt = (i == WIDTH - 1) ? int'(x[WIDTH-1]) : int'(x[i+1]);
            sum = int'(x[i]) + nxt + int'(c[i]);
            c[i+1] = (sum >= 2);
        end
        return c;
    endfunction

    // Expected digit i as an integer in {-1, 0, +1}.
    function automatic int ref_digit(input logic [WIDTH-1:0] x, input int i);
        logic [WIDTH:0] c;
        c = ref_carry(x);
        return int'(x[i]) + int'(c[i]) - 2 * int'(c[i+1]);
    endfunction

    function automatic int decode_digit(input logic s, input logic m);
        if (!m) return 0;
        return s ? -1 : 1;
    endfunction

    // Checks all digit properties against an operand value.
    task automatic check_digits(input logic [WIDTH-1:0] v);
        int total;
        int exp_val;
        bit legal;
        bit sparse;
        bit exact;
        total = 0;
        legal = 1'b1;
        sparse = 1'b1;
        exact = 1'b1;
        for (int i = 0; i < WIDTH; i++) begin
            total += decode_digit(digit_sign[i], digit_mag[i]) * (1 << i);
            if (digit_sign[i] && !digit_mag[i]) legal = 1'b0;
            if (i > 0 && digit_mag[i] && digit_mag[i-1]) sparse = 1'b0;
            if (decode_digit(digit_sign[i], digit_mag[i]) != ref_digit(v, i)) exact = 1'b0;
        end
        exp_val = int'($signed(v));
        check(total == exp_val, "R1", "decoded value", total, exp_val);
        check(legal, "R2", "illegal code 10 present", {digit_sign, digit_mag}, 0);
        check(sparse, "R3", "adjacent nonzero digits", digit_mag, v);
        check(exact, "R4", "digit pattern", {digit_sign, digit_mag}, v);
    endtask

    // Streams NVALS operands, one per clock, in the order (k*stride) mod NVALS.
    task automatic stream_sweep(input int stride);
        logic [WIDTH-1:0] hist [NVALS];
        test_en = 1'b0;
        for (int k = 0; k < NVALS + 2; k++) begin
            @(negedge clk);
            if (k >= 2) check_digits(hist[k-2]);
            if (k < NVALS) begin
                hist[k] = WIDTH'((k * stride) % NVALS);
                operand = hist[k];
            end
        end
    endtask

    // Captures v in normal mode, then shifts both chains out and compares.
    task automatic capture_unload(input logic [WIDTH-1:0] v);
        logic [CHAIN-1:0] exp_chain [NUM_PATHS];
        logic [WIDTH:0]   c;
        c = ref_carry(v);
        for (int p = 0; p < NUM_PATHS; p++) begin
            for (int j = 0; j < SEG; j++) begin
                int idx;
                int d;
                idx = p * SEG + j;
                d = ref_digit(v, idx);
                exp_chain[p][2*j]           = c[idx];
                exp_chain[p][2*j+1]         = v[idx];
                exp_chain[p][2*SEG+2*j]     = (d != 0);
                exp_chain[p][2*SEG+2*j+1]   = (d < 0);
            end
        end
        @(negedge clk);
        operand = v;
        test_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        test_en = 1'b1;
        scan_in = '0;
        for (int m = 0; m < CHAIN; m++) begin
            for (int p = 0; p < NUM_PATHS; p++) begin
                int pos;
                string req;
                pos = CHAIN - 1 - m;
                if (pos == 0 && p == 0) req = "R9";
                else if (pos == 0 && p == NUM_PATHS / 2) req = "R10";
                else req = "R8";
                check(scan_out[p] == exp_chain[p][pos], req, "unloaded chain bit",
                      scan_out[p], exp_chain[p][pos]);
            end
            operand = ~operand;
            @(negedge clk);
        end
        test_en = 1'b0;
    endtask

    function automatic logic pattern_bit(input int p, input int k);
        if (p == 0) return (k % 3) == 0;
        return (((k / 2) % 2) == 1) ^ ((k % 5) == 0);
    endfunction

    // Shifts distinct patterns through every path and checks the delay.
    task automatic shift_patterns();
        test_en = 1'b1;
        for (int k = 0; k < 3 * CHAIN; k++) begin
            @(negedge clk);
            if (k >= CHAIN) begin
                for (int p = 0; p < NUM_PATHS; p++) begin
                    check(scan_out[p] == pattern_bit(p, k - CHAIN),
                          (p == 0) ? "R6" : "R7", "shifted bit",
                          scan_out[p], pattern_bit(p, k - CHAIN));
                end
            end
            for (int p = 0; p < NUM_PATHS; p++) scan_in[p] = pattern_bit(p, k);
            operand = WIDTH'(k * 13);
        end
    endtask

    task automatic check_cleared(input string what);
        check(digit_sign == '0 && digit_mag == '0, "R5", what,
              {digit_sign, digit_mag}, 0);
        check(scan_out == '0, "R5", {what, " scan_out"}, scan_out, 0);
    endtask

    initial begin
        rst_n = 1'b0;
        test_en = 1'b0;
        scan_in = '0;
        operand = 8'hA5;
        repeat (3) @(negedge clk);
        check_cleared("after power-up reset");
        rst_n = 1'b1;

        stream_sweep(1);
        stream_sweep(37);

        capture_unload(8'hB5);
        capture_unload(8'h80);
        capture_unload(8'h7F);
        capture_unload(8'h55);
        capture_unload(8'hFF);
        capture_unload(8'h3C);

        shift_patterns();

        // R5: reset while shifting, with the chain full of pattern bits.
        @(negedge clk);
        scan_in = '1;
        rst_n = 1'b0;
        @(negedge clk);
        check_cleared("reset during test mode");
        rst_n = 1'b1;
        test_en = 1'b0;

        stream_sweep(91);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule